// File: doc/BRIEF.md
# Digital Input Pattern Interrupt

This block watches a 32-bit digital input port and raises a single interrupt request when a selected trigger condition is met. A per-bit mask picks which inputs take part. The trigger can be one of three kinds: the masked inputs reaching a programmed compare value, any masked input changing from one clock to the next, or a rising edge on a separate strobe input.

When a trigger fires, the block latches a snapshot of the whole port into a capture register. This snapshot ignores the mask. It also sets a sticky status flag, which software clears by writing a one to it. The interrupt output is a level that follows the status flag, gated by an enable bit. All configuration goes through a simple single-cycle register bus. Writes take effect at the clock edge, and reads are combinational on the address.

The port inputs and the strobe are assumed to be synchronous to the block clock already. In this document, "fires" means that the trigger condition is seen in a clock cycle. Status and capture update at the edge that ends that cycle.

Top module: `dig_pattern_irq`

## Requirements
- R1: After reset, every register reads zero and irq_o is low. The register word addresses are: 0 control, 1 mask, 2 compare, 3 capture, 4 status.
- R2: Mask and compare read back as written. The control register holds the mode in bits [1:0] and the interrupt enable in bit 2, and reads back the same way. The mode codes are: 0 disabled, 1 match, 2 event, 3 strobe.
- R3: In match mode, a trigger fires in the first cycle where (pins & mask) equals (compare & mask). It does not fire again until that equality has become false and then true again. Changes on unmasked pins therefore never retrigger it.
- R4: In event mode, a trigger fires in any cycle where a masked pin differs from its value in the previous cycle. Changes on unmasked pins alone do not fire.
- R5: In strobe mode, a trigger fires in a cycle where strobe_i is high and was low in the previous cycle. The capture register then holds the pin value of that cycle, even if the pins change afterwards. Holding strobe_i high does not retrigger.
- R6: When a trigger fires, all 32 pin values of that cycle are written to the capture register, whatever the mask.
- R7: A host write to the capture register takes effect only while the mode is disabled. In any other mode, the write leaves the capture register unchanged.
- R8: Status bit 0 is set by a trigger and stays set until a write to the status register with bit 0 equal to 1. A write with bit 0 equal to 0 does not clear it. If a trigger and a clearing write fall in the same cycle, the flag ends up set.
- R9: irq_o is high exactly while status bit 0 and the interrupt enable are both 1.
- R10: In disabled mode no trigger fires. In the first cycle after event or strobe mode is entered from disabled, no trigger fires either, so pin or strobe activity from before or during enabling causes no spurious event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |
| pins_i | input | 32 | Monitored digital inputs |
| strobe_i | input | 1 | Strobe input used in strobe mode |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two functions can act in the same cycle: a trigger setting the status flag, and a host write clearing it. The bench provokes this by raising strobe_i in the same cycle as a one-to-clear write to the status register. It then expects the flag and irq_o to stay high, because the set must win.

A second overlap is a trigger and a capture write. The bench aims a capture write at an armed mode and expects the capture register to stay unchanged. The behavioural model in the bench tracks every register and irq_o, and is compared with the outputs on every clock.

// File: rtl/dpi_pkg.sv
package dpi_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_MATCH  = 2'd1,
    MODE_EVENT  = 2'd2,
    MODE_STROBE = 2'd3
  } trig_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CAPT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

  localparam int CTRL_IE_BIT = 2;
endpackage

// File: rtl/dpi_trigger.sv
module dpi_trigger
  import dpi_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  trig_mode_e   mode_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] pins_i,
  input  logic         strobe_i,
  output logic         fire_o
);
  logic [W-1:0] prev_q;
  logic         prev_stb_q;
  logic         hist_ok_q;
  logic         cond_q;
  logic [W-1:0] bit_eq;
  logic [W-1:0] bit_chg;
  logic         cond;

  // per-bit masked compare and masked change
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i]  = ~mask_i[i] | (pins_i[i] ~^ cmp_i[i]);
    assign bit_chg[i] = mask_i[i] & (pins_i[i] ^ prev_q[i]);
  end

  assign cond = &bit_eq;

  always_comb begin
    unique case (mode_i)
      MODE_MATCH:  fire_o = cond & ~cond_q;
      MODE_EVENT:  fire_o = hist_ok_q & (|bit_chg);
      MODE_STROBE: fire_o = hist_ok_q & strobe_i & ~prev_stb_q;
      default:     fire_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_stb_q <= 1'b0;
      hist_ok_q  <= 1'b0;
      cond_q     <= 1'b0;
    end else begin
      prev_q     <= pins_i;
      prev_stb_q <= strobe_i;
      hist_ok_q  <= (mode_i != MODE_OFF);
      cond_q     <= (mode_i != MODE_OFF) & cond;
    end
  end
endmodule

// File: rtl/dpi_regs.sv
module dpi_regs
  import dpi_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic              fire_i,
  input  logic [W-1:0]      pins_i,
  output trig_mode_e        mode_o,
  output logic              ie_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      cmp_o,
  output logic [W-1:0]      capt_o,
  output logic              stat_o
);
  logic wr_ctrl, wr_mask, wr_cmp, wr_capt, wr_stat;

  assign wr_ctrl = bus_we_i && (bus_addr_i == ADR_CTRL);
  assign wr_mask = bus_we_i && (bus_addr_i == ADR_MASK);
  assign wr_cmp  = bus_we_i && (bus_addr_i == ADR_CMP);
  assign wr_capt = bus_we_i && (bus_addr_i == ADR_CAPT);
  assign wr_stat = bus_we_i && (bus_addr_i == ADR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_OFF;
      ie_o   <= 1'b0;
      mask_o <= '0;
      cmp_o  <= '0;
      capt_o <= '0;
      stat_o <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_o <= trig_mode_e'(bus_wdata_i[1:0]);
        ie_o   <= bus_wdata_i[CTRL_IE_BIT];
      end
      if (wr_mask) mask_o <= bus_wdata_i;
      if (wr_cmp)  cmp_o  <= bus_wdata_i;
      // trigger snapshot wins; host write only while disabled
      if (fire_i) capt_o <= pins_i;
      else if (wr_capt && mode_o == MODE_OFF) capt_o <= bus_wdata_i;
      // set beats clear
      if (fire_i) stat_o <= 1'b1;
      else if (wr_stat && bus_wdata_i[0]) stat_o <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADR_CTRL: begin
        bus_rdata_o[1:0]         = mode_o;
        bus_rdata_o[CTRL_IE_BIT] = ie_o;
      end
      ADR_MASK: bus_rdata_o    = mask_o;
      ADR_CMP:  bus_rdata_o    = cmp_o;
      ADR_CAPT: bus_rdata_o    = capt_o;
      ADR_STAT: bus_rdata_o[0] = stat_o;
      default:  bus_rdata_o    = '0;
    endcase
  end
endmodule

// File: rtl/dig_pattern_irq.sv
module dig_pattern_irq
  import dpi_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic [W-1:0]      pins_i,
  input  logic              strobe_i,
  output logic              irq_o
);
  trig_mode_e   mode_w;
  logic         ie_w;
  logic [W-1:0] mask_w;
  logic [W-1:0] cmp_w;
  logic [W-1:0] capt_w;
  logic         stat_w;
  logic         fire_w;

  dpi_trigger #(.W(W)) u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_w),
    .mask_i   (mask_w),
    .cmp_i    (cmp_w),
    .pins_i   (pins_i),
    .strobe_i (strobe_i),
    .fire_o   (fire_w)
  );

  dpi_regs #(.W(W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .fire_i      (fire_w),
    .pins_i      (pins_i),
    .mode_o      (mode_w),
    .ie_o        (ie_w),
    .mask_o      (mask_w),
    .cmp_o       (cmp_w),
    .capt_o      (capt_w),
    .stat_o      (stat_w)
  );

  assign irq_o = stat_w & ie_w;
endmodule

// File: rtl/dpi_chk.sv
module dpi_chk
  import dpi_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [W-1:0]      bus_wdata_i,
  input logic [W-1:0]      pins_i,
  input trig_mode_e        mode_i,
  input logic [W-1:0]      capt_i,
  input logic              stat_i,
  input logic              fire_i,
  input logic              irq_i
);
  logic clr_wr, ie_wr;
  assign clr_wr = bus_we_i && bus_addr_i == ADR_STAT && bus_wdata_i[0];
  assign ie_wr  = bus_we_i && bus_addr_i == ADR_CTRL && bus_wdata_i[CTRL_IE_BIT];

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i && !clr_wr) |=> stat_i);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> stat_i);

  a_r6_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (capt_i == $past(pins_i)));

  a_r7_capt_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_OFF && !fire_i) |=> $stable(capt_i));

  a_r10_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |-> !fire_i);

  a_r3_match_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && mode_i == MODE_MATCH) |=> !(fire_i && mode_i == MODE_MATCH));

  a_r9_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> ($past(fire_i) || $past(ie_wr)));
endmodule

bind dig_pattern_irq dpi_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pins_i      (pins_i),
  .mode_i      (mode_w),
  .capt_i      (capt_w),
  .stat_i      (stat_w),
  .fire_i      (fire_w),
  .irq_i       (irq_o)
);

// File: tb/sim_dig_pattern_irq.sv
module sim_dig_pattern_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        stb = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [1:0]  m_mode = 0;
  logic        m_ie = 0;
  logic [31:0] m_mask = 0, m_cmp = 0, m_capt = 0, m_prev = 0;
  logic        m_stat = 0, m_prev_stb = 0, m_armed = 0, m_cond_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dig_pattern_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pins_i(pins),
    .strobe_i(stb), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: model_read = {29'd0, m_ie, m_mode};
      3'd1: model_read = m_mask;
      3'd2: model_read = m_cmp;
      3'd3: model_read = m_capt;
      3'd4: model_read = {31'd0, m_stat};
      default: model_read = '0;
    endcase
  endfunction

  // one clock: update model from this edge's inputs, then compare away from the edge
  task automatic step();
    logic f, cond;
    @(posedge clk);
    cond = ((pins & m_mask) == (m_cmp & m_mask));
    case (m_mode)
      2'd1: f = cond && !m_cond_prev;
      2'd2: f = m_armed && (((pins ^ m_prev) & m_mask) != 0);
      2'd3: f = m_armed && stb && !m_prev_stb;
      default: f = 1'b0;
    endcase
    m_cond_prev = (m_mode != 0) ? cond : 1'b0;
    m_armed     = (m_mode != 0);
    m_prev      = pins;
    m_prev_stb  = stb;
    if (f) m_capt = pins;
    else if (we && addr == 3'd3 && m_mode == 2'd0) m_capt = wdata;
    if (f) m_stat = 1'b1;
    else if (we && addr == 3'd4 && wdata[0]) m_stat = 1'b0;
    if (we && addr == 3'd0) begin m_mode = wdata[1:0]; m_ie = wdata[2]; end
    if (we && addr == 3'd1) m_mask = wdata;
    if (we && addr == 3'd2) m_cmp = wdata;
    @(negedge clk);
    #1;
    check({31'd0, irq}, {31'd0, m_stat & m_ie}, "R9 model irq");
    check(rdata, model_read(addr), "R2 model readback");
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(rdata, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check({31'd0, irq}, 32'd0, "R1 irq after reset");
    for (int a = 0; a < 5; a++) rd(3'(a), 32'd0, "R1 reset register");

    // R2 readback
    wr(3'd1, 32'h0000_FF00);
    wr(3'd2, 32'h0000_5600);
    rd(3'd1, 32'h0000_FF00, "R2 mask");
    rd(3'd2, 32'h0000_5600, "R2 compare");
    // R7 capture writable while disabled
    wr(3'd3, 32'h1357_9BDF);
    rd(3'd3, 32'h1357_9BDF, "R7 capture write when off");

    // R3 match mode
    wr(3'd0, 32'h5);
    rd(3'd0, 32'h5, "R2 control");
    step();
    rd(3'd4, 32'd0, "R3 no match yet");
    pins = 32'hABCD_5611;
    step();
    check({31'd0, irq}, 32'd1, "R3 match fires");
    rd(3'd3, 32'hABCD_5611, "R6 capture ignores mask");
    wr(3'd4, 32'h1);
    rd(3'd4, 32'd0, "R3 held match no refire");
    pins = 32'hFFFF_56FF;
    step();
    rd(3'd4, 32'd0, "R3 unmasked change no refire");
    pins = 32'h0;
    step();
    pins = 32'h1111_5600;
    step();
    rd(3'd4, 32'd1, "R3 refire after false");
    rd(3'd3, 32'h1111_5600, "R6 capture on refire");
    // R7 capture write ignored while enabled
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd3, 32'h1111_5600, "R7 capture locked");

    // R4 event mode
    wr(3'd4, 32'h1);
    wr(3'd0, 32'h6);
    step(); step();
    pins = 32'h2222_5600;
    step();
    rd(3'd4, 32'd0, "R4 unmasked change ignored");
    pins = 32'h2222_5700;
    step();
    rd(3'd4, 32'd1, "R4 masked change fires");
    rd(3'd3, 32'h2222_5700, "R6 event capture");

    // R10 disabled mode
    wr(3'd4, 32'h1);
    wr(3'd0, 32'h4);
    pins = 32'h0;
    step();
    rd(3'd4, 32'd0, "R10 off no fire");
    wr(3'd3, 32'hCAFE_F00D);
    rd(3'd3, 32'hCAFE_F00D, "R7 capture write when off again");
    wr(3'd0, 32'h6);
    pins = 32'h0000_FF00;
    step();
    rd(3'd4, 32'd0, "R10 first cycle after enable quiet");
    pins = 32'h0000_FE00;
    step();
    rd(3'd4, 32'd1, "R4 fires after history valid");

    // R5 strobe mode
    wr(3'd4, 32'h1);
    wr(3'd0, 32'h7);
    step();
    pins = 32'h5A5A_5A5A; stb = 1'b1;
    step();
    pins = 32'h0;
    step();
    rd(3'd3, 32'h5A5A_5A5A, "R5 capture at strobe edge");
    rd(3'd4, 32'd1, "R5 strobe fires");
    wr(3'd4, 32'h1);
    step();
    rd(3'd4, 32'd0, "R5 held strobe no refire");
    stb = 1'b0;
    step();

    // R9 enable gating
    wr(3'd0, 32'h3);
    stb = 1'b1;
    step();
    stb = 1'b0;
    rd(3'd4, 32'd1, "R9 status set");
    check({31'd0, irq}, 32'd0, "R9 irq masked by enable");
    wr(3'd0, 32'h7);
    check({31'd0, irq}, 32'd1, "R9 irq after enable");

    // R8 set beats clear, write of zero keeps flag
    wr(3'd4, 32'h1);
    step();
    we = 1'b1; addr = 3'd4; wdata = 32'h1; stb = 1'b1;
    step();
    we = 1'b0;
    rd(3'd4, 32'd1, "R8 set wins over clear");
    wr(3'd4, 32'h0);
    rd(3'd4, 32'd1, "R8 zero write no clear");
    check({31'd0, irq}, 32'd1, "R8 irq stays");
    wr(3'd4, 32'h1);
    rd(3'd4, 32'd0, "R8 one write clears");
    stb = 1'b0;
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule